// File: doc/BRIEF.md
# Signed Power-of-Two Divider

This block divides a signed two's-complement word by a power of two, 2^n, where n is the shift amount given on a separate input. A bare arithmetic right shift rounds every negative quotient toward minus infinity. For example, -1 shifted by one place stays -1.

To avoid this, the block first adds a bias of 2^n - 1 to negative operands. It then shifts. The quotient that results truncates toward zero, in the same way as ordinary integer division. Non-negative operands pass through the shift with no bias. The biased sum is formed one bit wider than the operand, so it never wraps.

The data width is a parameter. An output-mode parameter selects one of two variants: a purely combinational result, or a result held in a register and presented one clock after the operands. It is intended for datapaths that need exact signed division by constants or run-time powers of two. It has no divider array.

Top module: `pow2_sdiv`

## Requirements
- R1: For a non-negative dividend, the quotient equals the dividend shifted right by n places, which is the floor of dividend / 2^n.
- R2: For a negative dividend, the quotient equals dividend / 2^n truncated toward zero. This is achieved by adding 2^n - 1 before an arithmetic shift.
- R3: With n = 1, a dividend of all ones (-1) gives a quotient of 0. It does not give -1.
- R4: A shift amount of 0 returns the dividend unchanged, for every dividend value.
- R5: At the most negative dividend, n = 0 returns that same value and n = DATA_W-1 returns -1. Neither case raises any overflow indication.
- R6: In registered mode, the quotient for operands presented before a rising clock edge appears on the output after that edge.
- R7: In registered mode, the output is 0 while reset (active low) is asserted.
- R8: A non-negative dividend never gives a negative quotient. A negative dividend never gives a positive quotient.
- R9: Shift amounts 0 to DATA_W-1 are all valid. The shift-amount input is clog2(DATA_W) bits wide, and DATA_W must be a power of two of at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output mode |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| dividend | input | DATA_W | Signed two's-complement operand |
| shamt | input | clog2(DATA_W) | Exponent n of the divisor 2^n |
| quotient | output | DATA_W | Signed quotient, truncated toward zero |

## Verification
The assertions check three relations on every cycle:
- the sign relation between dividend and quotient,
- the identity at shift amount 0,
- the n = 1 rule that turns -1 into 0.

Only the bench's scenarios can show the exact quotient values against truncating integer division. These scenarios cover every shift amount and both signs, including odd and even negatives, the extreme values, and the reset value of the registered output.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Output presentation of the quotient.
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

endpackage

// File: rtl/sdiv_bias.sv
// Adds 2^n - 1 to negative operands, in a result one bit wider than the operand.
module sdiv_bias #(
   parameter int DATA_W  = 16,
   parameter int SHIFT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  op_in,
   input  logic [SHIFT_W-1:0] shift_in,
   output logic [DATA_W:0]    biased_out
);

   localparam int EXT_W = DATA_W + 1;

   logic [DATA_W-1:0] low_mask;
   logic              is_neg;
   logic [EXT_W-1:0]  op_ext;
   logic [EXT_W-1:0]  bias_ext;

   // Thermometer mask: bit i is set when i < n, giving 2^n - 1.
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign low_mask[i] = (shift_in > SHIFT_W'(i));
   end

   assign is_neg   = op_in[DATA_W-1];
   assign op_ext   = {op_in[DATA_W-1], op_in};
   assign bias_ext = {1'b0, low_mask} & {EXT_W{is_neg}};

   always_comb begin
      biased_out = op_ext + bias_ext;
   end

endmodule

// File: rtl/sdiv_sra.sv
// Logarithmic arithmetic right shifter. The sign bit is replicated into the vacated positions.
module sdiv_sra #(
   parameter int DATA_W  = 16,
   parameter int SHIFT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W:0]    val_in,
   input  logic [SHIFT_W-1:0] shift_in,
   output logic [DATA_W-1:0]  val_out
);

   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] stage [SHIFT_W+1];

   assign stage[0] = val_in;

   for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic [EXT_W-1:0] shifted;
      assign shifted = {{STEP{stage[k][EXT_W-1]}}, stage[k][EXT_W-1:STEP]};
      assign stage[k+1] = shift_in[k] ? shifted : stage[k];
   end

   assign val_out = stage[SHIFT_W][DATA_W-1:0];

endmodule

// File: rtl/sdiv_outstage.sv
// Presents the quotient either directly or through a reset register.
module sdiv_outstage #(
   parameter int                 DATA_W   = 16,
   parameter sdiv_pkg::out_mode_e OUT_MODE = sdiv_pkg::OUT_REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] q_in,
   output logic [DATA_W-1:0] q_out
);

   if (OUT_MODE == sdiv_pkg::OUT_REG) begin : g_reg
      logic [DATA_W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= q_in;
      end
      assign q_out = q_r;
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign q_out     = q_in;
   end

endmodule

// File: rtl/pow2_sdiv.sv
// Signed division by 2^n with the quotient truncated toward zero.
module pow2_sdiv #(
   parameter int                 DATA_W   = 16,
   parameter sdiv_pkg::out_mode_e OUT_MODE = sdiv_pkg::OUT_REG,
   localparam int                SHIFT_W  = $clog2(DATA_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  dividend,
   input  logic [SHIFT_W-1:0] shamt,
   output logic [DATA_W-1:0]  quotient
);

   // R9: elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_width
      $error("pow2_sdiv: DATA_W must be at least 2");
   end
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_pow2
      $error("pow2_sdiv: DATA_W must be a power of two");
   end

   logic [DATA_W:0]   biased;
   logic [DATA_W-1:0] shifted;

   sdiv_bias #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_bias (
      .op_in      (dividend),
      .shift_in   (shamt),
      .biased_out (biased)
   );

   sdiv_sra #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_sra (
      .val_in   (biased),
      .shift_in (shamt),
      .val_out  (shifted)
   );

   sdiv_outstage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .q_in  (shifted),
      .q_out (quotient)
   );

endmodule

// File: rtl/pow2_sdiv_chk.sv
module pow2_sdiv_chk #(
   parameter int                 DATA_W   = 16,
   parameter sdiv_pkg::out_mode_e OUT_MODE = sdiv_pkg::OUT_REG,
   parameter int                 SHIFT_W  = $clog2(DATA_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DATA_W-1:0]  dividend,
   input logic [SHIFT_W-1:0] shamt,
   input logic [DATA_W-1:0]  quotient
);

   if (OUT_MODE == sdiv_pkg::OUT_REG) begin : g_reg_chk
      logic armed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) armed <= 1'b0;
         else        armed <= 1'b1;
      end

      // R4
      shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(shamt) == '0) |-> (quotient == $past(dividend)));

      // R3
      minus_one_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         (($past(dividend) == '1) && ($past(shamt) != '0)) |-> (quotient == '0));

      // R8
      pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         !$past(dividend[DATA_W-1]) |-> !quotient[DATA_W-1]);

      // R8
      neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(dividend[DATA_W-1]) |-> (quotient[DATA_W-1] || (quotient == '0)));

      // R7
      reset_val_chk: assert property (@(posedge clk)
         (!rst_n && !$past(rst_n)) |-> (quotient == '0));
   end else begin : g_comb_chk
      always_comb begin
         // R4
         shift_zero_chk: assert (shamt != '0 || quotient == dividend);
         // R8
         pos_sign_chk: assert (dividend[DATA_W-1] || !quotient[DATA_W-1]);
      end
   end

endmodule

bind pow2_sdiv pow2_sdiv_chk #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dividend (dividend),
   .shamt    (shamt),
   .quotient (quotient)
);

// File: tb/pow2_sdiv_bench.sv
`timescale 1ns/1ps
module pow2_sdiv_bench;

   localparam int W  = 16;
   localparam int SW = $clog2(W);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  dividend = '0;
   logic [SW-1:0] shamt = '0;
   logic [W-1:0]  quotient;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   pow2_sdiv #(.DATA_W(W), .OUT_MODE(sdiv_pkg::OUT_REG)) u_pow2_sdiv (
      .clk(clk), .rst_n(rst_n), .dividend(dividend), .shamt(shamt), .quotient(quotient)
   );

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Compare the entry queued one step earlier, then drive new operands.
   task automatic step(input int d, input int n, input string tag);
      @(negedge clk);
      if (exp_q.size() > 0) check(int'($signed(quotient)), exp_q.pop_front(), tag_q.pop_front());
      dividend = W'(d);
      shamt    = SW'(n);
      // Reference: integer division truncating toward zero.
      exp_q.push_back(d / (1 << n));
      tag_q.push_back(tag);
   endtask

   task automatic flush();
      @(negedge clk);
      if (exp_q.size() > 0) check(int'($signed(quotient)), exp_q.pop_front(), tag_q.pop_front());
   endtask

   initial begin
      int vals[12] = '{0, 1, -1, 2, -2, 7, -7, 12345, -12345, 32767, -32768, -32767};
      // R7: output held at zero during reset
      dividend = 16'h8001;
      shamt    = 4'd3;
      repeat (3) @(negedge clk);
      check(int'($signed(quotient)), 0, "R7");
      rst_n = 1'b1;

      // R3: -1 / 2 gives 0
      step(-1, 1, "R3");
      step(-3, 1, "R2");
      step(-4, 1, "R2");
      // R4: shift zero is identity
      step(-12345, 0, "R4");
      step(32767, 0, "R4");
      // R5: extremes
      step(-32768, 0, "R5");
      step(-32768, W-1, "R5");
      step(32767, W-1, "R1");
      // R9/R1/R2/R8: every shift amount, both signs
      for (int n = 0; n < W; n++) begin
         foreach (vals[i]) step(vals[i], n, vals[i] < 0 ? "R2" : "R1");
      end
      // R6: back-to-back operands each yield their own quotient next cycle
      for (int i = 0; i < 400; i++) begin
         int d = int'($signed(16'($urandom())));
         step(d, int'($urandom_range(W-1, 0)), "R6");
      end
      flush();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule